// File: doc/BRIEF.md
# One-Time-Programmable Page Program Sequencer

This block is a host-side controller that programs one page of the one-time-programmable (OTP) area of a flash device. It reaches the device only through a 16-bit memory-mapped register bus: address, write data, write strobe, read strobe, read data and a ready handshake. A single start pulse runs a fixed command script. The script selects the block, enters OTP access mode and waits for the device interrupt bit. It then reads the controller status, streams the page data into the device's data buffer and sets the page and buffer addresses. After that it issues the program command, waits for the interrupt again and reads the status a second time. Every run closes with a reset command that takes the device out of OTP mode.

The host supplies the data words through an index/data pair. It also gives a reset command code, a page number, a buffer-select word for dual-die parts, an auto-interrupt option and a timeout in cycles for each interrupt wait. At the end of the script the block pulses done for one cycle. It then holds pass, fail, lock and timeout flags until the next start.

Top module: `otp_prog_seq`

## Requirements
- R1: A clean run performs these writes, in order: 0000h to F100h; the optional steps of R2 and R3; 0065h to F220h; WORDS data writes of data_word_i to DBUF_BASE+i for i = 0..WORDS-1; 0000h to F100h; the page word to F107h; 0800h to F200h; 0080h to F220h; and finally rst_cmd_i to F220h.
- R2: When auto_int_i=0, the block writes 0000h to F241h just before each of the 0065h and 0080h commands. When auto_int_i=1, it makes neither write.
- R3: The write of buf_sel_i to F101h comes right after the first F100h write, and it happens only when dual_die_i=1.
- R4: After each of the 0065h and 0080h commands, the block keeps reading F241h. It moves on only after a read that returns bit 15 = 1.
- R5: After each interrupt wait, the block reads F240h. If bit 10 = 1, it sets fail_o, skips the rest of the script and goes straight to the reset write. lock_o is set when bits 14 and 10 are both 1.
- R6: If bit 15 of F241h has not been seen set within timeout_i cycles of a wait, the block sets timeout_o and fail_o and goes on to the reset write. Any access already in flight finishes first.
- R7: Every run, whatever its outcome, ends with the rst_cmd_i write to F220h. done_o pulses for exactly one cycle after that write completes.
- R8: Only one access is outstanding at a time. Address, data and strobes stay stable until bus_rdy_i, and write and read strobes are never high together.
- R9: A start_i pulse while busy_o=1 is ignored.
- R10: At done_o, exactly one of pass_o and fail_o is 1. All flags keep their values until the next accepted start clears them.
- R11: The F107h word is {page_i, 2'b00}, so the sector field is 00. The F200h word is 0800h: buffer sector 1000, count 000.
- R12: After reset the block is idle: no strobes, and busy_o, done_o and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| auto_int_i | input | 1 | Device clears its interrupt itself; skip clear writes |
| dual_die_i | input | 1 | Dual-die part; write the buffer-select word |
| buf_sel_i | input | 16 | Buffer-select word for F101h |
| page_i | input | 14 | Page number placed above the 2-bit sector field |
| rst_cmd_i | input | 16 | Reset command code written to F220h at exit |
| timeout_i | input | TO_W | Interrupt wait limit in cycles |
| data_idx_o | output | IDX_W | Index of the data word being written |
| data_word_i | input | 16 | Data word for data_idx_o |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_wr_o | output | 1 | Write strobe, held until ready |
| bus_rd_o | output | 1 | Read strobe, held until ready |
| bus_rdata_i | input | 16 | Read data, valid with ready |
| bus_rdy_i | input | 1 | Access completes in this cycle |
| busy_o | output | 1 | Script running |
| done_o | output | 1 | One-cycle end-of-script pulse |
| pass_o | output | 1 | Program succeeded |
| fail_o | output | 1 | Error, lock or timeout |
| lock_o | output | 1 | OTP area reported locked |
| timeout_o | output | 1 | An interrupt wait timed out |

## Verification
The hardest branches to reach from the ports are the early exits. One is an error status right after OTP entry, which must skip all data writes. The other is an interrupt that never arrives, where the timeout can expire in the middle of an outstanding poll. The bench reaches both with a register-file responder. Each command can be given its own interrupt delay, including "never", and each status read can return its own injected value. Ready latency alternates between accesses, so the holding of requests is exercised. The ordered list of completed writes is checked against a list built from the requirements.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  localparam logic [15:0] ADDR_BLK    = 16'hF100;
  localparam logic [15:0] ADDR_DIESEL = 16'hF101;
  localparam logic [15:0] ADDR_PAGE   = 16'hF107;
  localparam logic [15:0] ADDR_BUFSET = 16'hF200;
  localparam logic [15:0] ADDR_CMD    = 16'hF220;
  localparam logic [15:0] ADDR_STAT   = 16'hF240;
  localparam logic [15:0] ADDR_IRQ    = 16'hF241;
  localparam logic [15:0] CMD_OTP     = 16'h0065;
  localparam logic [15:0] CMD_PROG    = 16'h0080;
  localparam logic [15:0] BUFSET_VAL  = 16'h0800;
  localparam int          IRQ_BIT     = 15;
  localparam int          ERR_BIT     = 10;
  localparam int          LOCK_BIT    = 14;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BLK, ST_DIESEL, ST_CLR_A, ST_ENTER, ST_WAIT_A, ST_STAT_A,
    ST_DATA, ST_BLK2, ST_PAGE, ST_BUFSET, ST_CLR_B, ST_PROG, ST_WAIT_B,
    ST_STAT_B, ST_EXIT
  } seq_state_e;
endpackage

// File: rtl/otp_bus_port.sv
module otp_bus_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        req_wr_i,
  input  logic [15:0] req_addr_i,
  input  logic [15:0] req_wdata_i,
  input  logic        bus_rdy_i,
  output logic [15:0] bus_addr_o,
  output logic [15:0] bus_wdata_o,
  output logic        bus_wr_o,
  output logic        bus_rd_o,
  output logic        ack_o,
  output logic        active_o
);
  logic        active_q, active_d;
  logic        wr_q;
  logic [15:0] addr_q, wdata_q;
  logic        launch;

  assign launch = req_i && !active_q;

  always_comb begin
    active_d = active_q;
    if (launch)                     active_d = 1'b1;
    else if (active_q && bus_rdy_i) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      active_q <= active_d;
      if (launch) begin
        wr_q    <= req_wr_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_wr_o    = active_q && wr_q;
  assign bus_rd_o    = active_q && !wr_q;
  assign ack_o       = active_q && bus_rdy_i;
  assign active_o    = active_q;

  // R8: request held stable while the bus is not ready
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !bus_rdy_i) |=> ($stable(bus_addr_o) && $stable(bus_wdata_o)
                                  && $stable(bus_wr_o) && $stable(bus_rd_o)));
  // R8: never a read and a write at once
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_o && bus_rd_o));
endmodule

// File: rtl/otp_int_timer.sv
module otp_int_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q, cnt_d;

  assign expired_o = run_i && (cnt_q >= limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)          cnt_d = '0;
    else if (!expired_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: the window restarts at every wait
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int          WORDS     = 8,
  parameter int          TO_W      = 16,
  parameter logic [15:0] DBUF_BASE = 16'h0200,
  localparam int         IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             auto_int_i,
  input  logic             dual_die_i,
  input  logic [15:0]      buf_sel_i,
  input  logic [13:0]      page_i,
  input  logic [15:0]      rst_cmd_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic [IDX_W-1:0] data_idx_o,
  input  logic [15:0]      data_word_i,
  output logic [15:0]      bus_addr_o,
  output logic [15:0]      bus_wdata_o,
  output logic             bus_wr_o,
  output logic             bus_rd_o,
  input  logic [15:0]      bus_rdata_i,
  input  logic             bus_rdy_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             lock_o,
  output logic             timeout_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pass_q, pass_d, fail_q, fail_d;
  logic             lock_q, lock_d, to_q, to_d, done_q, done_d;

  logic        req, req_wr, ack, active, waiting, expired;
  logic [15:0] req_addr, req_wdata;
  logic        irq_set, err_set, lock_set;
  logic        unused_rdata;

  assign irq_set      = bus_rdata_i[IRQ_BIT];
  assign err_set      = bus_rdata_i[ERR_BIT];
  assign lock_set     = bus_rdata_i[LOCK_BIT] && bus_rdata_i[ERR_BIT];
  assign unused_rdata = ^{bus_rdata_i[13:11], bus_rdata_i[9:0]};
  assign waiting      = (state_q == ST_WAIT_A) || (state_q == ST_WAIT_B);

  otp_bus_port u_port (
    .clk, .rst_n,
    .req_i(req), .req_wr_i(req_wr), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .bus_rdy_i, .bus_addr_o, .bus_wdata_o, .bus_wr_o, .bus_rd_o,
    .ack_o(ack), .active_o(active)
  );

  otp_int_timer #(.TO_W(TO_W)) u_timer (
    .clk, .rst_n, .run_i(waiting), .limit_i(timeout_i), .expired_o(expired)
  );

  // request decode per script step
  always_comb begin
    req       = 1'b1;
    req_wr    = 1'b1;
    req_addr  = ADDR_BLK;
    req_wdata = 16'h0000;
    unique case (state_q)
      ST_IDLE:   req = 1'b0;
      ST_BLK, ST_BLK2: req_addr = ADDR_BLK;
      ST_DIESEL: begin req_addr = ADDR_DIESEL; req_wdata = buf_sel_i;  end
      ST_CLR_A, ST_CLR_B: req_addr = ADDR_IRQ;
      ST_ENTER:  begin req_addr = ADDR_CMD;    req_wdata = CMD_OTP;    end
      ST_WAIT_A, ST_WAIT_B: begin
        req = !expired; req_wr = 1'b0; req_addr = ADDR_IRQ;
      end
      ST_STAT_A, ST_STAT_B: begin req_wr = 1'b0; req_addr = ADDR_STAT; end
      ST_DATA:   begin
        req_addr  = DBUF_BASE + 16'(idx_q);
        req_wdata = data_word_i;
      end
      ST_PAGE:   begin req_addr = ADDR_PAGE;   req_wdata = {page_i, 2'b00}; end
      ST_BUFSET: begin req_addr = ADDR_BUFSET; req_wdata = BUFSET_VAL; end
      ST_PROG:   begin req_addr = ADDR_CMD;    req_wdata = CMD_PROG;   end
      ST_EXIT:   begin req_addr = ADDR_CMD;    req_wdata = rst_cmd_i;  end
      default:   req = 1'b0;
    endcase
  end

  // next state and flags
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pass_d  = pass_q;
    fail_d  = fail_q;
    lock_d  = lock_q;
    to_d    = to_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_BLK;
        {pass_d, fail_d, lock_d, to_d} = 4'b0000;
      end
      ST_BLK: if (ack)
        state_d = dual_die_i ? ST_DIESEL : (auto_int_i ? ST_ENTER : ST_CLR_A);
      ST_DIESEL: if (ack) state_d = auto_int_i ? ST_ENTER : ST_CLR_A;
      ST_CLR_A:  if (ack) state_d = ST_ENTER;
      ST_ENTER:  if (ack) state_d = ST_WAIT_A;
      ST_WAIT_A, ST_WAIT_B: begin
        if (ack && irq_set)
          state_d = (state_q == ST_WAIT_A) ? ST_STAT_A : ST_STAT_B;
        else if (expired && !active) begin
          state_d = ST_EXIT; to_d = 1'b1; fail_d = 1'b1;
        end
      end
      ST_STAT_A: if (ack) begin
        if (err_set) begin
          state_d = ST_EXIT; fail_d = 1'b1; lock_d = lock_set;
        end else begin
          state_d = ST_DATA; idx_d = '0;
        end
      end
      ST_DATA: if (ack) begin
        if (idx_q == LAST_IDX) state_d = ST_BLK2;
        else                   idx_d   = idx_q + 1'b1;
      end
      ST_BLK2:   if (ack) state_d = ST_PAGE;
      ST_PAGE:   if (ack) state_d = ST_BUFSET;
      ST_BUFSET: if (ack) state_d = auto_int_i ? ST_PROG : ST_CLR_B;
      ST_CLR_B:  if (ack) state_d = ST_PROG;
      ST_PROG:   if (ack) state_d = ST_WAIT_B;
      ST_STAT_B: if (ack) begin
        state_d = ST_EXIT;
        fail_d  = err_set;
        pass_d  = !err_set;
        lock_d  = lock_set;
      end
      ST_EXIT: if (ack) begin
        state_d = ST_IDLE; done_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      lock_q  <= 1'b0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      lock_q  <= lock_d;
      to_q    <= to_d;
      done_q  <= done_d;
    end
  end

  assign data_idx_o = idx_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign lock_o     = lock_q;
  assign timeout_o  = to_q;

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: done only follows the exit write
  p_done_after_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o);
  // R10: outcome is exactly one of pass or fail
  p_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o != fail_o));
  // R10: flags hold while idle without a start
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable({pass_o, fail_o, lock_o, timeout_o}));
  // R5: lock implies fail
  p_lock_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> fail_o);
  // R6: timeout implies fail
  p_to_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> fail_o);
  // R9: start while busy does not end a run
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(ack && state_q == ST_EXIT)) |=> busy_o);
endmodule

// File: tb/otp_prog_seq_tb_top.sv
module otp_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 8;
  localparam int TO_W       = 16;
  localparam logic [15:0] DBUF    = 16'h0200;
  localparam logic [15:0] RST_CMD = 16'h00F0;
  localparam logic [15:0] BUFSEL  = 16'h0003;
  localparam logic [13:0] PAGE    = 14'h0015;

  logic clk, rst_n, start_i, auto_int_i, dual_die_i;
  logic [2:0]  data_idx_o;
  logic [15:0] data_word_i, bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic        bus_wr_o, bus_rd_o, bus_rdy_i;
  logic        busy_o, done_o, pass_o, fail_o, lock_o, timeout_o;
  logic [TO_W-1:0] timeout_i;

  int n_checks, n_fail, cyc;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];

  // responder configuration
  int          cfg_d1, cfg_d2, int_cd, lat, lat_sel, polls;
  logic [15:0] cfg_s1, cfg_s2;
  logic        int_reg, prog_issued;
  logic        m_busy, m_done;

  assign data_word_i = 16'hC300 + 16'(data_idx_o) * 16'h0111;

  otp_prog_seq #(.WORDS(WORDS), .TO_W(TO_W), .DBUF_BASE(DBUF)) dut_i (
    .clk, .rst_n, .start_i, .auto_int_i, .dual_die_i,
    .buf_sel_i(BUFSEL), .page_i(PAGE), .rst_cmd_i(RST_CMD), .timeout_i,
    .data_idx_o, .data_word_i, .bus_addr_o, .bus_wdata_o, .bus_wr_o, .bus_rd_o,
    .bus_rdata_i, .bus_rdy_i, .busy_o, .done_o, .pass_o, .fail_o, .lock_o, .timeout_o
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // register-file responder, acts away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_rdy_i = 1'b0; bus_rdata_i = '0; int_reg = 1'b0; int_cd = 0;
      lat = 0; lat_sel = 0; prog_issued = 1'b0;
    end else begin
      if (int_cd > 0) begin
        int_cd--;
        if (int_cd == 0) int_reg = 1'b1;
      end
      if (bus_wr_o || bus_rd_o) begin
        if (lat >= lat_sel) begin
          bus_rdy_i = 1'b1; lat = 0; lat_sel = (lat_sel == 0) ? 2 : 0;
          if (bus_wr_o) begin
            got_q.push_back({bus_addr_o, bus_wdata_o});
            if (bus_addr_o == 16'hF241) int_reg = bus_wdata_o[15];
            if (bus_addr_o == 16'hF220 && (bus_wdata_o == 16'h0065 || bus_wdata_o == 16'h0080)) begin
              if (auto_int_i) int_reg = 1'b0;
              if (bus_wdata_o == 16'h0080) begin
                prog_issued = 1'b1; int_cd = (cfg_d2 < 0) ? 0 : cfg_d2;
              end else int_cd = (cfg_d1 < 0) ? 0 : cfg_d1;
            end
          end else begin
            if (bus_addr_o == 16'hF241) begin
              bus_rdata_i = {int_reg, 15'h0}; polls++;
            end else if (bus_addr_o == 16'hF240)
              bus_rdata_i = prog_issued ? cfg_s2 : cfg_s1;
            else bus_rdata_i = 16'h0;
          end
        end else begin
          bus_rdy_i = 1'b0; lat++;
        end
      end else begin
        bus_rdy_i = 1'b0; lat = 0;
      end
    end
  end

  // behavioural busy/done model updated at every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start_i) m_busy <= 1'b1;
      else if (m_busy && bus_wr_o && bus_rdy_i && bus_addr_o == 16'hF220 && bus_wdata_o == RST_CMD) begin
        m_busy <= 1'b0; m_done <= 1'b1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o === m_busy, "R9 busy tracks model", 32'(busy_o), 32'(m_busy));
      chk(done_o === m_done, "R7 done pulse timing", 32'(done_o), 32'(m_done));
      chk(!(bus_wr_o && bus_rd_o), "R8 exclusive strobes", 32'(bus_wr_o), 32'(0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic push_w(input logic [15:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic run_case(input string name, input bit dual, input bit autom,
                          input logic [15:0] s1, input logic [15:0] s2,
                          input int d1, input int d2, input bit extra_start,
                          input bit e_fail, input bit e_lock, input bit e_to,
                          input int min_polls);
    int dones;
    bit early;
    exp_q.delete(); got_q.delete();
    cfg_s1 = s1; cfg_s2 = s2; cfg_d1 = d1; cfg_d2 = d2; polls = 0;
    dual_die_i = dual; auto_int_i = autom; prog_issued = 1'b0; int_reg = 1'b0;
    // expected ordered writes from R1, R2, R3, R5, R6, R11
    push_w(16'hF100, 16'h0000);
    if (dual) push_w(16'hF101, BUFSEL);
    if (!autom) push_w(16'hF241, 16'h0000);
    push_w(16'hF220, 16'h0065);
    early = (d1 < 0) || s1[10];
    if (!early) begin
      for (int i = 0; i < WORDS; i++) push_w(DBUF + 16'(i), 16'hC300 + 16'(i) * 16'h0111);
      push_w(16'hF100, 16'h0000);
      push_w(16'hF107, {PAGE, 2'b00});
      push_w(16'hF200, 16'h0800);
      if (!autom) push_w(16'hF241, 16'h0000);
      push_w(16'hF220, 16'h0080);
    end
    push_w(16'hF220, RST_CMD);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    dones = 0;
    for (int c = 0; c < 4000 && dones == 0; c++) begin
      @(negedge clk);
      if (c == 20 && extra_start) start_i = 1'b1;
      if (c == 21) start_i = 1'b0;
      if (done_o) dones++;
    end
    chk(dones == 1, {name, " R7 done seen"}, 32'(dones), 32'(1));
    chk(pass_o == !e_fail, {name, " R10 pass"}, 32'(pass_o), 32'(!e_fail));
    chk(fail_o == e_fail, {name, " R5 fail"}, 32'(fail_o), 32'(e_fail));
    chk(lock_o == e_lock, {name, " R5 lock"}, 32'(lock_o), 32'(e_lock));
    chk(timeout_o == e_to, {name, " R6 timeout"}, 32'(timeout_o), 32'(e_to));
    chk(polls >= min_polls, {name, " R4 polled"}, 32'(polls), 32'(min_polls));
    chk(got_q.size() == exp_q.size(), {name, " R1 write count"}, 32'(got_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {name, " R1 ordered write"}, got_q[i], exp_q[i]);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    chk(dones == 1, {name, " R9 no second run"}, 32'(dones), 32'(1));
    chk({pass_o, fail_o, lock_o, timeout_o} == {!e_fail, e_fail, e_lock, e_to},
        {name, " R10 flags hold"}, 32'({pass_o, fail_o, lock_o, timeout_o}),
        32'({!e_fail, e_fail, e_lock, e_to}));
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cyc = 0;
    start_i = 1'b0; auto_int_i = 1'b0; dual_die_i = 1'b0; timeout_i = 16'd60;
    cfg_d1 = 3; cfg_d2 = 3; cfg_s1 = 0; cfg_s2 = 0; polls = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk({bus_wr_o, bus_rd_o, busy_o, done_o} == 4'b0, "R12 idle bus", 32'({bus_wr_o, bus_rd_o, busy_o, done_o}), 0);
    chk({pass_o, fail_o, lock_o, timeout_o} == 4'b0, "R12 flags clear", 32'({pass_o, fail_o, lock_o, timeout_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2 R11: single die, clear writes, clean program
    run_case("base", 1'b0, 1'b0, 16'h0000, 16'h0000, 3, 4, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    // R3 R2: dual die with auto interrupt
    run_case("dual_auto", 1'b1, 1'b1, 16'h0000, 16'h0000, 2, 2, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    // R4: long delay forces repeated polling
    run_case("slow_int", 1'b0, 1'b0, 16'h0000, 16'h0000, 30, 40, 1'b0, 1'b0, 1'b0, 1'b0, 6);
    // R5: program error without lock
    run_case("prog_err", 1'b0, 1'b1, 16'h0000, 16'h0400, 3, 3, 1'b0, 1'b1, 1'b0, 1'b0, 2);
    // R5: locked area
    run_case("locked", 1'b1, 1'b0, 16'h0000, 16'h4400, 3, 3, 1'b0, 1'b1, 1'b1, 1'b0, 2);
    // R5: error after OTP entry skips data
    run_case("enter_err", 1'b0, 1'b0, 16'h0400, 16'h0000, 3, 3, 1'b0, 1'b1, 1'b0, 1'b0, 1);
    // R6: interrupt never arrives after entry
    run_case("to_enter", 1'b0, 1'b0, 16'h0000, 16'h0000, -1, 3, 1'b0, 1'b1, 1'b0, 1'b1, 1);
    // R6: interrupt never arrives after program
    run_case("to_prog", 1'b1, 1'b1, 16'h0000, 16'h0000, 3, -1, 1'b0, 1'b1, 1'b0, 1'b1, 2);
    // R9: start pulse during run is ignored
    run_case("busy_start", 1'b0, 1'b0, 16'h0000, 16'h0000, 3, 3, 1'b1, 1'b0, 1'b0, 1'b0, 2);
    // R10: pass run after failures clears old flags
    run_case("recover", 1'b0, 1'b1, 16'h0000, 16'h0000, 5, 5, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule